// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a small 32-bit processor that completes one instruction in every clock cycle. Its program sits in an internal word-organised instruction store, which is filled through a dedicated load port. The core fetches from that store at the byte address held in its program counter. It decodes three fixed 32-bit formats: register, immediate and jump. It executes register add and subtract, add with a signed constant, word load, word store, plain jump and jump with link. Operands come from a 32-entry register file, and words are moved to and from an internal data store.

A two-state controller decides when the core runs. While the load port is writing, the controller is in `ST_LOAD`. In that state the program counter is held at zero and nothing executes. On the first clock edge at which the load port is idle, the controller moves to `ST_RUN`, and execution starts from address 0. A write on the load port while in `ST_RUN` sends the controller back to `ST_LOAD`. The transitions are named LOAD_HOLD, LOAD_TO_RUN, RUN_TO_LOAD and RUN_STAY. Synchronous reset puts the controller in `ST_LOAD`.

Debug outputs show the current program counter and the register write that the current instruction will commit at the next clock edge. A sticky flag records any load or store that was refused because its address was not a multiple of 4.

Top module: `core_top`

## Requirements
- R1: While reset is held, the state is `ST_LOAD`, `dbg_pc` reads 0, `dbg_wr_en` is low and `misalign_flag` is low.
- R2: While `prog_we` is high, the word `prog_data` is written to instruction slot `prog_addr`. In that cycle no instruction commits, and from the next edge the PC is 0. The first edge with `prog_we` low moves `ST_LOAD` to `ST_RUN`, and execution then begins at PC 0.
- R3: Opcode 0 (bits [31:26]) is the register format. Bits [25:21] select the first source, bits [20:16] the second source and bits [15:11] the destination. Function code [5:0] = 32 adds the sources and 34 subtracts the second from the first, with the result taken modulo 2^32. Any other function code is a no-operation.
- R4: Opcode 8 writes the register selected by [20:16] with the first source plus the sign-extended 16-bit field [15:0].
- R5: Register 0 always reads as zero. A result aimed at register 0 is discarded, and `dbg_wr_en` stays low for it.
- R6: Opcode 35 (load) and opcode 43 (store) use the address first source + sign-extended [15:0]. A load writes the addressed data word into register [20:16]. A store writes register [20:16] into that word.
- R7: A load or store whose address has bit 1 or bit 0 set changes neither a register nor memory. From the next edge it sets `misalign_flag`, which stays high until reset.
- R8: Unless a jump executes, the next PC is PC+4. Opcode 2 sets the next PC to {PC[31:28], [25:0], 2'b00}.
- R9: Opcode 3 jumps like opcode 2 and, in the same cycle, writes PC+4 into register 31.
- R10: Any other opcode is a no-operation that only advances the PC by 4.
- R11: `dbg_pc` shows the address of the instruction being executed. `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` show, in that same cycle, the register write that commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Instruction store write strobe; holds the core in `ST_LOAD` |
| prog_addr | input | $clog2(IMEM_WORDS) | Instruction slot index (word index) |
| prog_data | input | 32 | Instruction word to store |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_idx | output | 5 | Register being written |
| dbg_wr_data | output | 32 | Value being written |
| misalign_flag | output | 1 | Sticky flag for refused misaligned loads and stores |

## Verification
The write port and the PC are visible in the same cycle as the instruction that produces them. A wrong decode, operand or PC update therefore shows at the ports within one instruction. State that stays hidden, such as data-store words or the contents of register 31, is checked by a later instruction that reads it back onto the write port. Every data-store word the program touches and every register it reads is read back this way a few cycles after it is written, including words that a refused store must have left unchanged. A controller stuck in the wrong state shows up at once: either a write appears during loading, or the PC fails to restart at 0.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [5:0] OPC_REG  = 6'd0;
    localparam logic [5:0] OPC_JMP  = 6'd2;
    localparam logic [5:0] OPC_JAL  = 6'd3;
    localparam logic [5:0] OPC_ADDI = 6'd8;
    localparam logic [5:0] OPC_LW   = 6'd35;
    localparam logic [5:0] OPC_SW   = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;

    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREG - 1);

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } core_state_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_sel_e;

    typedef struct packed {
        logic              reg_we;
        logic [RIDX_W-1:0] dst;
        logic              alu_sub;
        logic              use_imm;
        logic              mem_rd;
        logic              mem_wr;
        logic              jump;
        wb_sel_e           wb_sel;
    } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [RIDX_W-1:0] src_a,
    output logic [RIDX_W-1:0] src_b,
    output logic [XLEN-1:0]   imm_sext
);

    logic [5:0] opc;
    logic [5:0] fn;
    logic       unused_shamt;

    assign opc          = instr[31:26];
    assign fn           = instr[5:0];
    assign src_a        = instr[25:21];
    assign src_b        = instr[20:16];
    assign imm_sext     = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign unused_shamt = ^instr[10:6];

    always_comb begin
        ctrl         = '0;
        ctrl.wb_sel  = WB_ALU;
        case (opc)
            OPC_REG: begin
                ctrl.dst = instr[15:11];
                if (fn == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                end else if (fn == FN_SUB) begin
                    ctrl.reg_we  = 1'b1;
                    ctrl.alu_sub = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = instr[20:16];
                ctrl.use_imm = 1'b1;
            end
            OPC_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst     = instr[20:16];
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_sel  = WB_MEM;
            end
            OPC_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_JMP: begin
                ctrl.jump = 1'b1;
            end
            OPC_JAL: begin
                ctrl.jump   = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.dst    = LINK_REG;
                ctrl.wb_sel = WB_LINK;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        AST_CLASS_EXCLUSIVE: assert ($onehot0({ctrl.mem_rd, ctrl.mem_wr, ctrl.jump})); // R6
        AST_STORE_NO_REGWRITE: assert (!(ctrl.mem_wr && ctrl.reg_we)); // R6
    end

endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int WIDTH   = XLEN,
    parameter int ENTRIES = NREG,
    localparam int IW     = $clog2(ENTRIES)
)(
    input  logic             clk,
    input  logic [IW-1:0]    rd_idx_a,
    input  logic [IW-1:0]    rd_idx_b,
    output logic [WIDTH-1:0] rd_val_a,
    output logic [WIDTH-1:0] rd_val_b,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_val
);

    logic [WIDTH-1:0] regs [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx != '0)) begin
            regs[wr_idx] <= wr_val;
        end
    end

    assign rd_val_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
    assign rd_val_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];

endmodule

// File: rtl/core_dmem.sv
module core_dmem
    import core_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS)
)(
    input  logic            clk,
    input  logic [AW-1:0]   idx,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] rd_val
);

    logic [XLEN-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_val;
        end
    end

    assign rd_val = mem[idx];

endmodule

// File: rtl/core_top.sv
module core_top
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 16,
    localparam int IAW       = $clog2(IMEM_WORDS),
    localparam int DAW       = $clog2(DMEM_WORDS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [IAW-1:0]    prog_addr,
    input  logic [XLEN-1:0]   prog_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [RIDX_W-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]   dbg_wr_data,
    output logic              misalign_flag
);

    core_state_e       state, state_nx;
    logic [XLEN-1:0]   pc, pc_plus4, pc_nx, jump_tgt;
    logic [XLEN-1:0]   imem [IMEM_WORDS];
    logic [XLEN-1:0]   instr;
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] src_a, src_b;
    logic [XLEN-1:0]   imm_sext, val_a, val_b, alu_b, alu_res, eff_addr, mem_rd_val;
    logic              run_en, mem_access, misaligned, mem_block, dmem_we;
    logic              misalign_q;
    logic              unused_addr;

    // instruction store, written only through the load port
    always_ff @(posedge clk) begin
        if (prog_we) begin
            imem[prog_addr] <= prog_data;
        end
    end

    assign instr = imem[pc[IAW+1:2]];

    // controller: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    // controller: transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: state_nx = prog_we ? ST_LOAD : ST_RUN;  // LOAD_HOLD / LOAD_TO_RUN
            ST_RUN:  state_nx = prog_we ? ST_LOAD : ST_RUN;  // RUN_TO_LOAD / RUN_STAY
            default: state_nx = ST_LOAD;
        endcase
    end

    assign run_en = (state == ST_RUN) && !prog_we;

    core_decode u_decode (
        .instr    (instr),
        .ctrl     (ctrl),
        .src_a    (src_a),
        .src_b    (src_b),
        .imm_sext (imm_sext)
    );

    core_regfile #(
        .WIDTH   (XLEN),
        .ENTRIES (NREG)
    ) u_regs (
        .clk      (clk),
        .rd_idx_a (src_a),
        .rd_idx_b (src_b),
        .rd_val_a (val_a),
        .rd_val_b (val_b),
        .wr_en    (dbg_wr_en),
        .wr_idx   (dbg_wr_idx),
        .wr_val   (dbg_wr_data)
    );

    // datapath
    assign alu_b      = ctrl.use_imm ? imm_sext : val_b;
    assign alu_res    = ctrl.alu_sub ? (val_a - alu_b) : (val_a + alu_b);
    assign eff_addr   = alu_res;
    assign mem_access = ctrl.mem_rd || ctrl.mem_wr;
    assign misaligned = eff_addr[1:0] != 2'b00;
    assign mem_block  = mem_access && misaligned;
    assign dmem_we    = run_en && ctrl.mem_wr && !misaligned;
    assign unused_addr = ^eff_addr[XLEN-1:DAW+2];

    core_dmem #(
        .WORDS (DMEM_WORDS)
    ) u_dmem (
        .clk    (clk),
        .idx    (eff_addr[DAW+1:2]),
        .wr_en  (dmem_we),
        .wr_val (val_b),
        .rd_val (mem_rd_val)
    );

    // next-PC
    assign pc_plus4 = pc + XLEN'(4);
    assign jump_tgt = {pc[XLEN-1:XLEN-4], instr[25:0], 2'b00};
    assign pc_nx    = ctrl.jump ? jump_tgt : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            pc <= '0;
        end else begin
            pc <= pc_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            misalign_q <= 1'b0;
        end else if (run_en && mem_block) begin
            misalign_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        dbg_pc        = pc;
        misalign_flag = misalign_q;
        dbg_wr_idx    = ctrl.dst;
        dbg_wr_en     = run_en && ctrl.reg_we && !mem_block && (ctrl.dst != '0);
        unique case (ctrl.wb_sel)
            WB_MEM:  dbg_wr_data = mem_rd_val;
            WB_LINK: dbg_wr_data = pc_plus4;
            default: dbg_wr_data = alu_res;
        endcase
    end

    AST_LOAD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> !dbg_wr_en); // R2

    AST_LOAD_PC_ZERO: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> (dbg_pc == '0)); // R2

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (rst)
        (run_en && !ctrl.jump) |=> (dbg_pc == $past(pc) + XLEN'(4))); // R8

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (run_en && ctrl.jump) |=> (dbg_pc == {$past(pc[XLEN-1:XLEN-4]), $past(instr[25:0]), 2'b00})); // R8

    AST_LINK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (run_en && ctrl.jump && ctrl.reg_we) |-> (dbg_wr_en && dbg_wr_idx == LINK_REG && dbg_wr_data == pc + XLEN'(4))); // R9

    AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (mem_access && eff_addr[1:0] != 2'b00) |-> (!dmem_we && !dbg_wr_en)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        misalign_flag |=> misalign_flag); // R7

    AST_R0_DISCARD: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> (dbg_wr_idx != '0)); // R5

endmodule

// File: tb/tb_core_top.sv
module tb_core_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        prog_we;
    logic [5:0]  prog_addr;
    logic [31:0] prog_data;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;
    logic        misalign_flag;

    always #2.5 clk = ~clk;

    core_top dut (
        .clk           (clk),
        .rst           (rst),
        .prog_we       (prog_we),
        .prog_addr     (prog_addr),
        .prog_data     (prog_data),
        .dbg_pc        (dbg_pc),
        .dbg_wr_en     (dbg_wr_en),
        .dbg_wr_idx    (dbg_wr_idx),
        .dbg_wr_data   (dbg_wr_data),
        .misalign_flag (misalign_flag)
    );

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit mon_on = 0;

    logic [31:0] q_pc[$];
    logic        q_we[$];
    logic [4:0]  q_idx[$];
    logic [31:0] q_data[$];
    logic        q_flag[$];
    string       q_tag[$];

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] pc, input logic we, input int idx, input logic [31:0] data,
                        input logic flag, input string tag);
        q_pc.push_back(pc);
        q_we.push_back(we);
        q_idx.push_back(5'(idx));
        q_data.push_back(data);
        q_flag.push_back(flag);
        q_tag.push_back(tag);
    endtask

    // monitor: compare one executed instruction per cycle against the scoreboard
    always @(negedge clk) begin
        if (mon_on && q_pc.size() > 0) begin
            automatic logic [31:0] e_pc   = q_pc.pop_front();
            automatic logic        e_we   = q_we.pop_front();
            automatic logic [4:0]  e_idx  = q_idx.pop_front();
            automatic logic [31:0] e_data = q_data.pop_front();
            automatic logic        e_flag = q_flag.pop_front();
            automatic string       e_tag  = q_tag.pop_front();
            check({e_tag, "/R11"}, "pc", dbg_pc, e_pc);
            check(e_tag, "wr_en", 32'(dbg_wr_en), 32'(e_we));
            if (e_we) begin
                check(e_tag, "wr_idx", 32'(dbg_wr_idx), 32'(e_idx));
                check(e_tag, "wr_data", dbg_wr_data, e_data);
            end
            check(e_tag, "flag", 32'(misalign_flag), 32'(e_flag));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    logic [31:0] prog [31];

    initial begin
        for (int i = 0; i < 31; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(8, 0, 1, 5);          // r1 = 5
        prog[1]  = enc_i(8, 0, 2, -3);         // r2 = -3
        prog[2]  = enc_r(1, 2, 3, 32);         // r3 = r1 + r2
        prog[3]  = enc_r(2, 1, 4, 34);         // r4 = r2 - r1
        prog[4]  = enc_i(8, 1, 0, 7);          // write to r0, discarded
        prog[5]  = enc_i(8, 0, 5, 9);          // r5 = r0 + 9
        prog[6]  = enc_i(43, 0, 3, 8);         // mem[8] = r3
        prog[7]  = enc_i(43, 0, 5, 4);         // mem[4] = r5
        prog[8]  = enc_i(43, 0, 1, 6);         // misaligned store
        prog[9]  = enc_i(35, 0, 6, 4);         // r6 = mem[4]
        prog[10] = enc_i(8, 0, 8, 12);         // r8 = 12
        prog[11] = enc_i(35, 8, 7, -4);        // r7 = mem[8]
        prog[12] = enc_i(35, 0, 9, 2);         // misaligned load
        prog[13] = enc_i(8, 0, 12, 16'h8000);  // r12 = sext(0x8000)
        prog[14] = enc_i(8, 0, 10, -1);        // r10 = -1
        prog[15] = enc_r(10, 1, 11, 32);       // r11 = -1 + 5, wraps
        prog[16] = 32'hFC00_0000;              // unknown opcode 63
        prog[17] = enc_r(1, 1, 13, 0);         // register format, function 0
        prog[18] = enc_j(3, 25);               // jal -> 100
        prog[25] = enc_r(31, 0, 14, 32);       // r14 = r31
        prog[26] = enc_j(2, 30);               // j -> 120
        prog[30] = enc_j(2, 30);               // self loop

        rst = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc", dbg_pc, 32'h0);
        check("R1", "wr_en", 32'(dbg_wr_en), 32'h0);
        check("R1", "flag", 32'(misalign_flag), 32'h0);

        rst = 1'b0;
        for (int i = 0; i < 31; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
            @(negedge clk);
            check("R2", "wr_en during load", 32'(dbg_wr_en), 32'h0);
            check("R2", "pc during load", dbg_pc, 32'h0);
        end

        push(0,   1, 1,  32'd5,        0, "R4");
        push(4,   1, 2,  32'hFFFFFFFD, 0, "R4");
        push(8,   1, 3,  32'd2,        0, "R3");
        push(12,  1, 4,  32'hFFFFFFF8, 0, "R3");
        push(16,  0, 0,  0,            0, "R5");
        push(20,  1, 5,  32'd9,        0, "R5");
        push(24,  0, 0,  0,            0, "R6");
        push(28,  0, 0,  0,            0, "R6");
        push(32,  0, 0,  0,            0, "R7");
        push(36,  1, 6,  32'd9,        1, "R7");
        push(40,  1, 8,  32'd12,       1, "R4");
        push(44,  1, 7,  32'd2,        1, "R6");
        push(48,  0, 0,  0,            1, "R7");
        push(52,  1, 12, 32'hFFFF8000, 1, "R4");
        push(56,  1, 10, 32'hFFFFFFFF, 1, "R4");
        push(60,  1, 11, 32'd4,        1, "R3");
        push(64,  0, 0,  0,            1, "R10");
        push(68,  0, 0,  0,            1, "R3");
        push(72,  1, 31, 32'd76,       1, "R9");
        push(100, 1, 14, 32'd76,       1, "R9");
        push(104, 0, 0,  0,            1, "R8");
        push(120, 0, 0,  0,            1, "R8");
        push(120, 0, 0,  0,            1, "R8");
        push(120, 0, 0,  0,            1, "R8");

        prog_we = 1'b0;
        @(posedge clk);
        mon_on = 1'b1;
        while (q_pc.size() > 0) @(negedge clk);
        mon_on = 1'b0;

        // back into loading from running
        prog_we = 1'b1; prog_addr = 6'd40; prog_data = 32'h0;
        #0.1;
        check("R2", "wr_en while reloading", 32'(dbg_wr_en), 32'h0);
        @(negedge clk);
        check("R2", "pc after reload", dbg_pc, 32'h0);
        check("R7", "flag kept", 32'(misalign_flag), 32'h1);
        push(0, 1, 1, 32'd5, 1, "R2");
        prog_we = 1'b0;
        @(posedge clk);
        mon_on = 1'b1;
        while (q_pc.size() > 0) @(negedge clk);
        mon_on = 1'b0;

        rst = 1'b1;
        @(negedge clk);
        check("R1", "flag cleared by reset", 32'(misalign_flag), 32'h0);
        check("R1", "pc after reset", dbg_pc, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule